// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog for a processor subsystem. A timeout counter advances on the rising edges of a slow tick. The tick comes from its own oscillator, so it enters through a synchroniser. Software restarts the count with a kick strobe. If no kick arrives before the selected period ends, the block either raises an interrupt or pulses a system reset and records that the watchdog caused it.

Software sees two byte-wide registers. The control register holds the interrupt flag, the interrupt enable, the watchdog enable and a four-bit period code. The status register holds the sticky reset-cause flag. Turning the watchdog off or changing its period needs a two-step sequence. First a write sets the change-enable bit and the enable bit together. Then a second write lands within a few bus clocks. Outside that short window the watchdog can only be switched on, so a stray write cannot silence it.

Top module: `wdog_guard`

## Requirements
- R1: After `rst` the control register reads 0x00 and the status register reads 0x00. `irq` and `sys_reset` are low.
- R2: Control register (`bus_addr`=0) layout: bit 7 interrupt flag, bit 6 interrupt enable, bit 4 reads 1 while the unlock window is open, bit 3 watchdog enable. The period code is {bit 5, bits 2..0}. In the status register (`bus_addr`=1), bit 0 is the reset-cause flag and the other bits read 0.
- R3: With period code n (0..9), expiry comes on the 2^(BASE_LOG2+n)-th tick rising edge after the last restart. The tick passes through a two-flop synchroniser before counting.
- R4: Period codes 10 to 15 give the same period as code 9.
- R5: A `kick` pulse restarts the count, so kicks spaced closer than the period prevent any expiry.
- R6: Expiry with enable=1 and interrupt enable=0 produces a one-cycle `sys_reset` pulse. The control register returns to 0x00 and the count restarts.
- R7: A watchdog reset sets the reset-cause flag. The flag survives that reset. Only `rst` or a status write with bit 0 = 0 clears it. Writing 1 leaves it unchanged.
- R8: Expiry with interrupt enable=1 sets the interrupt flag. `irq` is high while both the flag and the enable are 1. With enable=0 no reset follows.
- R9: With enable and interrupt enable both 1, an expiry finding the flag clear only interrupts. An expiry finding the flag still set produces the watchdog reset.
- R10: Writing 1 to control bit 7 clears the interrupt flag. Writing 0 there leaves it unchanged.
- R11: A control write with bits 4 and 3 both 1 opens the unlock window. A control write inside the window loads the enable and the period code from the data. Outside the window a write can set the enable but cannot clear it, and leaves the period code unchanged.
- R12: The window covers the 4 bus clocks after the opening write. An in-window write that does not itself reopen the window closes it.
- R13: The interrupt enable follows every control write, with or without the window.
- R14: With enable=0 and interrupt enable=0 the counter holds at zero and nothing expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tick_async | input | 1 | Slow tick from the watchdog oscillator, asynchronous |
| kick | input | 1 | Restart strobe, one bus clock wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| sys_reset | output | 1 | One-cycle system reset request |
| reset_cause | output | 1 | Sticky watchdog reset-cause flag |

## Verification
On every cycle, the assertions check four things. The period code and a falling enable change only through an in-window write or a watchdog reset. The window opens only after an unlock write. The reset pulse lasts one cycle and always has the cause flag set and the enable behind it. The cause flag falls only for `rst` or an explicit clear. The bench's scenarios are needed for the behaviours that depend on sequences and on timing: exact period lengths per code, the clamping of large codes, kicks holding off expiry, the two-stage interrupt-then-reset escalation, and the exact edge of the four-clock window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int PSH_BIT  = 5;
    localparam int CE_BIT   = 4;
    localparam int EN_BIT   = 3;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       en;
        logic [3:0] ps;
    } wdog_ctrl_t;

    localparam wdog_ctrl_t CTRL_RESET = '{flag: 1'b0, ie: 1'b0, en: 1'b0, ps: 4'd0};

    function automatic logic [3:0] ps_of_byte(input logic [7:0] b);
        return {b[PSH_BIT], b[2:0]};
    endfunction

    function automatic logic is_unlock(input logic [7:0] b);
        return b[CE_BIT] & b[EN_BIT];
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input wdog_ctrl_t c, input logic win);
        logic [7:0] b;
        b           = 8'h00;
        b[FLAG_BIT] = c.flag;
        b[IE_BIT]   = c.ie;
        b[PSH_BIT]  = c.ps[3];
        b[CE_BIT]   = win;
        b[EN_BIT]   = c.en;
        b[2:0]      = c.ps[2:0];
        return b;
    endfunction

    function automatic logic [3:0] clamp_code(input logic [3:0] ps, input int max_code);
        if (int'(ps) > max_code) return 4'(max_code);
        return ps;
    endfunction

endpackage

// File: rtl/wdog_tick_sync.sv
module wdog_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_async,
    output logic tick_pulse
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], tick_async};
    end

    assign tick_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       kick,
    input  logic       tick,
    input  logic [3:0] ps,
    output logic       expire
);
    localparam int CW = BASE_LOG2 + MAX_CODE + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;
    logic [3:0]    code;

    assign code   = clamp_code(ps, MAX_CODE);
    assign last_q = (CW'(1) << (BASE_LOG2 + int'(code))) - CW'(1);
    assign expire = run & tick & ~kick & (cnt_q >= last_q);

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (kick | ~run | expire)  cnt_q <= '0;
        else if (tick)                  cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       set_flag,
    input  logic       wipe,
    output wdog_ctrl_t ctrl_q,
    output logic       win_open
);
    localparam int WW = $clog2(WIN_CYCLES + 1);

    logic [WW-1:0] win_q;
    wdog_ctrl_t    ctrl_d;
    logic [WW-1:0] win_d;

    assign win_open = (win_q != '0);

    always_comb begin
        ctrl_d = ctrl_q;
        if (set_flag)                  ctrl_d.flag = 1'b1;
        else if (wr_ctrl && wdata[FLAG_BIT]) ctrl_d.flag = 1'b0;
        if (wr_ctrl) begin
            ctrl_d.ie = wdata[IE_BIT];
            if (win_open) begin
                ctrl_d.en = wdata[EN_BIT];
                ctrl_d.ps = ps_of_byte(wdata);
            end else begin
                ctrl_d.en = ctrl_q.en | wdata[EN_BIT];
            end
        end
        if (wr_ctrl && is_unlock(wdata)) win_d = WW'(WIN_CYCLES);
        else if (wr_ctrl || !win_open)   win_d = '0;
        else                             win_d = win_q - WW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            ctrl_q <= CTRL_RESET;
            win_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            win_q  <= win_d;
        end
    end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2   = 11,
    parameter int MAX_CODE    = 9,
    parameter int WIN_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_async,
    input  logic       kick,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       sys_reset,
    output logic       reset_cause
);
    wdog_ctrl_t ctrl_q;
    logic       win_open;
    logic       tick_pulse;
    logic       expire;
    logic       run;
    logic       wd_rst;
    logic       irq_set;
    logic       sys_q;
    logic       cause_q;

    wdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .tick_async(tick_async), .tick_pulse(tick_pulse)
    );

    assign run = ctrl_q.en | ctrl_q.ie;

    wdog_counter #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .kick(kick), .tick(tick_pulse),
        .ps(ctrl_q.ps), .expire(expire)
    );

    // escalate to reset when interrupts are off or the last one went unserviced
    assign wd_rst  = expire & ctrl_q.en & (~ctrl_q.ie | ctrl_q.flag);
    assign irq_set = expire & ctrl_q.ie & ~wd_rst;

    wdog_ctrl_reg #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .wr_ctrl(bus_wr && !bus_addr), .wdata(bus_wdata),
        .set_flag(irq_set), .wipe(wd_rst), .ctrl_q(ctrl_q), .win_open(win_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_q   <= 1'b0;
            cause_q <= 1'b0;
        end else begin
            sys_q <= wd_rst;
            if (wd_rst)                                 cause_q <= 1'b1;
            else if (bus_wr && bus_addr && !bus_wdata[0]) cause_q <= 1'b0;
        end
    end

    assign bus_rdata   = bus_addr ? {7'b0, cause_q} : ctrl_to_byte(ctrl_q, win_open);
    assign irq         = ctrl_q.flag & ctrl_q.ie;
    assign sys_reset   = sys_q;
    assign reset_cause = cause_q;
endmodule

// File: rtl/wdog_guard_checker.sv
module wdog_guard_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       irq,
    input logic       sys_reset,
    input logic       reset_cause,
    input logic       flag,
    input logic       ie,
    input logic       en,
    input logic [3:0] ps,
    input logic       win_open,
    input logic       tick_pulse
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !sys_reset && !reset_cause));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        sys_reset |=> !sys_reset);

    p_cause_with_reset_r7: assert property (@(posedge clk) disable iff (rst)
        sys_reset |-> reset_cause);

    p_cause_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_cause) |-> ($past(rst) || $past(bus_wr && bus_addr && !bus_wdata[0])));

    p_flag_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick_pulse && ie));

    p_ps_locked_r11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ps) && !$past(rst)) |-> ($past(win_open && bus_wr && !bus_addr) || sys_reset));

    p_en_locked_r11: assert property (@(posedge clk) disable iff (rst)
        ($fell(en) && !$past(rst)) |-> ($past(win_open && bus_wr && !bus_addr) || sys_reset));

    p_win_open_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(win_open) |-> $past(bus_wr && !bus_addr && bus_wdata[4] && bus_wdata[3]));

    p_reset_needs_en_r14: assert property (@(posedge clk) disable iff (rst)
        sys_reset |-> $past(en));
endmodule

bind wdog_guard wdog_guard_checker u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .irq(irq), .sys_reset(sys_reset), .reset_cause(reset_cause),
    .flag(ctrl_q.flag), .ie(ctrl_q.ie), .en(ctrl_q.en), .ps(ctrl_q.ps),
    .win_open(win_open), .tick_pulse(tick_pulse)
);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
    localparam int BASE = 3;
    localparam int MAXC = 9;

    logic       clk = 0;
    logic       rst = 1;
    logic       tick_async = 0;
    logic       kick = 0;
    logic       bus_wr = 0;
    logic       bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       irq, sys_reset, reset_cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    wdog_guard #(.BASE_LOG2(BASE), .MAX_CODE(MAXC)) i_wdog_guard (
        .clk(clk), .rst(rst), .tick_async(tick_async), .kick(kick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .sys_reset(sys_reset), .reset_cause(reset_cause)
    );

    always #4 clk = ~clk;

    // slow tick: one rising edge every 4 bus clocks
    int tph = 0;
    always @(negedge clk) begin
        tph = (tph + 1) % 4;
        tick_async = (tph < 2);
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_s1, m_s2, m_s3, m_flag, m_ie, m_en, m_cause, m_sys;
    logic [3:0] m_ps;
    int m_cnt, m_win;

    always @(posedge clk) begin : model
        int code, lim;
        bit tp, run, ex, wdr, wr0, wo;
        logic [7:0] d, erd;
        if (rst) begin
            {m_s1, m_s2, m_s3, m_flag, m_ie, m_en, m_cause, m_sys} = '0;
            m_ps = 0; m_cnt = 0; m_win = 0;
        end else begin
            tp   = m_s2 && !m_s3;
            run  = m_en || m_ie;
            code = (int'(m_ps) > MAXC) ? MAXC : int'(m_ps);
            lim  = 1 << (BASE + code);
            ex   = run && tp && (m_cnt >= lim - 1) && !kick;
            wdr  = ex && m_en && (!m_ie || m_flag);
            wr0  = bus_wr && !bus_addr;
            d    = bus_wdata;
            wo   = (m_win != 0);
            if (wdr) begin
                m_flag = 0; m_ie = 0; m_en = 0; m_ps = 0; m_win = 0; m_cnt = 0;
                m_cause = 1; m_sys = 1;
            end else begin
                m_sys = 0;
                if (kick || !run || ex) m_cnt = 0;
                else if (tp) m_cnt++;
                if (ex && m_ie) m_flag = 1;
                else if (wr0 && d[7]) m_flag = 0;
                if (wr0) begin
                    m_ie = d[6];
                    m_en = wo ? d[3] : (m_en | d[3]);
                    if (wo) m_ps = {d[5], d[2:0]};
                end
                if (wr0 && d[4] && d[3]) m_win = 4;
                else if (wr0 && wo) m_win = 0;
                else if (wo) m_win--;
                if (bus_wr && bus_addr && !d[0]) m_cause = 0;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = tick_async;
        end
        #2;
        erd = bus_addr ? {7'b0, m_cause}
                       : {m_flag, m_ie, m_ps[3], (m_win != 0), m_en, m_ps[2:0]};
        chk("R2 model rdata", bus_rdata, erd);
        chk("R8 model irq", irq, m_flag && m_ie);
        chk("R6 model sys_reset", sys_reset, m_sys);
        chk("R7 model reset_cause", reset_cause, m_cause);
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a; #1; v = bus_rdata; bus_addr = 0;
    endtask

    task automatic do_kick();
        kick = 1; @(negedge clk); kick = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for sys_reset; returns cycles taken, or -1
    task automatic wait_rst(input int lim, output int cyc);
        cyc = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (sys_reset) begin cyc = i; break; end
        end
    endtask

    task automatic wait_irq(input int lim, output int cyc, output bit rst_seen);
        cyc = -1; rst_seen = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (sys_reset) rst_seen = 1;
            if (irq) begin cyc = i; break; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int cyc;
        bit rs;
        idle(3);
        rst = 0;
        idle(2);

        // R1 reset state
        rd(0, v); chk("R1 ctrl after reset", v, 8'h00);
        rd(1, v); chk("R1 status after reset", v, 8'h00);
        chk("R1 irq after reset", irq, 0);

        // R14 idle watchdog never fires
        wait_rst(1500, cyc); chk("R14 no reset while disabled", cyc, -1);
        chk("R14 no irq while disabled", irq, 0);

        // R11 enable may be set outside window, prescale not
        wr(0, 8'h08); rd(0, v); chk("R11 enable set outside window", v, 8'h08);
        wr(0, 8'h0B); rd(0, v); chk("R11 prescale locked outside window", v, 8'h08);
        wr(0, 8'h00); rd(0, v); chk("R11 enable not clearable outside window", v, 8'h08);
        // R13 interrupt enable always writable
        wr(0, 8'h48); rd(0, v); chk("R13 ie set", v, 8'h48);
        wr(0, 8'h08); rd(0, v); chk("R13 ie cleared", v, 8'h08);

        // R12 write on 4th clock after unlock accepted
        wr(0, 8'h18); rd(0, v); chk("R2 window visible in bit 4", v, 8'h18);
        idle(3); wr(0, 8'h0A); rd(0, v); chk("R12 write at window end accepted", v, 8'h0A);
        // R12 write on 5th clock rejected
        wr(0, 8'h18); idle(4); wr(0, 8'h00); rd(0, v);
        chk("R12 write after window rejected", v, 8'h08 | 8'h02);

        // R3 code 2: 32 ticks * 4 clocks
        do_kick(); wait_rst(1000, cyc);
        chk("R3 code2 period in range", (cyc >= 124 && cyc <= 136), 1);
        rd(0, v); chk("R6 control wiped by watchdog reset", v, 8'h00);
        chk("R7 cause set", reset_cause, 1);
        idle(1); chk("R6 reset pulse one cycle", sys_reset, 0);

        // R7 clear semantics
        wr(1, 8'h01); rd(1, v); chk("R7 write 1 keeps cause", v, 8'h01);
        wr(1, 8'h00); rd(1, v); chk("R7 write 0 clears cause", v, 8'h00);

        // R5 regular kicks hold off expiry (code 2)
        wr(0, 8'h18); wr(0, 8'h0A);
        for (int k = 0; k < 12; k++) begin
            do_kick(); wait_rst(80, cyc);
            chk("R5 kicked watchdog silent", cyc, -1);
        end
        // R11 disable through window stops it
        wr(0, 8'h18); wr(0, 8'h00); rd(0, v); chk("R11 disabled via window", v, 8'h00);
        wait_rst(400, cyc); chk("R11 disabled watchdog silent", cyc, -1);

        // R4 code 12 behaves as 9: 4096 ticks
        wr(0, 8'h18); wr(0, 8'h2C); rd(0, v); chk("R4 code 12 stored", v, 8'h2C);
        do_kick(); wait_rst(20000, cyc);
        chk("R4 clamped period in range", (cyc >= 16380 && cyc <= 16392), 1);
        wr(1, 8'h00);

        // R8 interrupt-only mode, code 0: 8 ticks
        wr(0, 8'h40); do_kick(); wait_irq(200, cyc, rs);
        chk("R8 irq raised", (cyc >= 28 && cyc <= 40), 1);
        chk("R8 no reset in interrupt mode", rs, 0);
        rd(0, v); chk("R8 flag visible", v, 8'hC0);
        // R10 write-1-to-clear
        wr(0, 8'h40); rd(0, v); chk("R10 write 0 keeps flag", v[7], 1);
        wr(0, 8'hC0); rd(0, v); chk("R10 write 1 clears flag", v[7], 0);
        chk("R10 irq drops", irq, 0);
        wr(0, 8'h00);

        // R9 escalation: irq first, reset on next expiry (code 1: 16 ticks)
        wr(0, 8'h18); wr(0, 8'h49); do_kick();
        wait_irq(200, cyc, rs);
        chk("R9 first expiry interrupts", (cyc >= 60 && cyc <= 72), 1);
        chk("R9 first expiry no reset", rs, 0);
        wait_rst(200, cyc);
        chk("R9 second expiry resets", (cyc >= 60 && cyc <= 72), 1);
        chk("R7 cause after escalation", reset_cause, 1);

        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule